// File: doc/BRIEF.md
# Weight-Stationary Convolution Row for a Spiking Input Layer

This block is one row of the dense engine that runs the first layer of a directly coded spiking network. The input layer sees multi-bit pixels rather than spikes. A 3x3 kernel over three input channels gives 27 coefficients, and each coefficient sits in its own multiply-accumulate cell. Each cell keeps its weight fixed for the whole output channel. Pixels enter each cell from above through a private delay chain whose length equals the cell's position. The running sum then moves one cell to the right on every clock. Once the pipeline has filled, the row emits one full membrane value per clock, in raster order over the output map.

A state machine with five named states controls the row. IDLE waits for `start`. CLEAR pulses `chan_clr` for one cycle: this clears every partial sum and tells the downstream neuron stage to drop its membrane state. In the same cycle the shadow weights, written over the weight port, are copied into the cells. ISSUE walks the output map one position per cycle and presents 27 read indices to the flop-based image store; taps that fall outside the image read as zero. DRAIN waits until the last result has left the row, then goes back to CLEAR for the next output channel, or to DONE after the last one. DONE holds `layer_done` until a new `start`. Transitions: IDLE->CLEAR on start, CLEAR->ISSUE always, ISSUE->DRAIN at the last map position, DRAIN->CLEAR or DRAIN->DONE when the pipeline is empty, DONE->CLEAR on start.

Top module: `ws_conv_row`

## Requirements
- R1: After reset, `mem_valid`, `chan_clr` and `layer_done` are all 0.
- R2: For output channel c and position (y,x), the value on `mem_value` is the signed sum over i in 0..2 and dy,dx in 0..2 of weight[i*9+dy*3+dx] times pixel(i, y+dy-1, x+dx-1). Pixel (i,r,q) is stored at image address i*IMG_H*IMG_W + r*IMG_W + q. Outputs come in raster order, x fastest.
- R3: A tap whose row or column falls outside the image contributes zero, so border outputs use only the in-image taps.
- R4: The first `mem_valid` of a channel arrives exactly 28 cycles after that channel's `chan_clr` cycle. It then stays high for IMG_H*IMG_W consecutive cycles, one result per cycle, and it is never high while `chan_clr` is high.
- R5: `chan_clr` is a single-cycle pulse. It appears in the cycle after `start` is accepted and once more before each further output channel, N_OCH pulses per layer in all.
- R6: Weight-port writes (`wt_we`, `wt_idx` 0..26 as in R2) go to a shadow set. The cells take the shadow set only in a `chan_clr` cycle, so writes made at any other time, including during the clear cycle itself, do not affect the channel being computed.
- R7: `layer_done` rises after the last result of the last channel and stays high until `start`. A `start` pulse while the layer is in progress is ignored.
- R8: Accumulation is 24-bit signed. With all pixels and weights at -128, an interior output is exactly 442368, with no wrap.
- R9: `out_ch` carries the index of the output channel whose results are currently on `mem_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a layer (accepted in IDLE or DONE) |
| pix_we | input | 1 | Image store write strobe |
| pix_addr | input | 8 | Image store write address (channel-major, row-major) |
| pix_data | input | 8 | Signed pixel written to the image store |
| wt_we | input | 1 | Shadow weight write strobe |
| wt_idx | input | 5 | Shadow weight index, 0..26 |
| wt_data | input | 8 | Signed weight value |
| mem_valid | output | 1 | Enable to the activation stage: a full sum is on `mem_value` |
| mem_value | output | 24 | Signed accumulated membrane contribution |
| out_ch | output | 2 | Output channel currently on `mem_value` |
| chan_clr | output | 1 | One-cycle reset of partial sums and downstream membrane state |
| layer_done | output | 1 | All output channels finished |

## Verification
The first layer pass uses a random image with its extreme values placed in the corners and different random weights for each channel. This separates a wrong tap-to-weight mapping, a wrong skew depth and a wrong padding rule, because each of these corrupts different output positions, and the border positions are counted separately. Between clear pulses the bench writes the next channel's weights, and after the last clear it writes junk weights. This shows whether weights are latched only at the clear. A second pass sets every pixel and weight to -128, which exposes any narrowing of the accumulator or any loss of sign in the products. In every pass each result is compared on the clock it appears, against a cycle position counted from its channel's clear, so an extra or missing pipeline stage is caught as well as a wrong value.

// File: rtl/ws_row_pkg.sv
package ws_row_pkg;
    localparam int PIX_W  = 8;
    localparam int ACC_W  = 24;
    localparam int KDIM   = 3;
    localparam int IN_CH  = 3;
    localparam int TAPS   = IN_CH * KDIM * KDIM;
    localparam int TAP_IW = $clog2(TAPS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ISSUE,
        ST_DRAIN,
        ST_DONE
    } row_state_e;
endpackage

// File: rtl/row_img_store.sv
module row_img_store
    import ws_row_pkg::*;
#(
    parameter int DEPTH = 192,
    parameter int AW    = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic signed [PIX_W-1:0] wdata,
    input  logic [AW-1:0]           raddr [TAPS],
    input  logic                    rok   [TAPS],
    output logic signed [PIX_W-1:0] rdata [TAPS]
);
    logic signed [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            mem[waddr] <= wdata;
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_rd
        always_comb begin
            if (rok[k] && (int'(raddr[k]) < DEPTH))
                rdata[k] = mem[raddr[k]];
            else
                rdata[k] = '0;
        end
    end
endmodule

// File: rtl/row_addr_gen.sv
module row_addr_gen
    import ws_row_pkg::*;
#(
    parameter int IMG_H = 8,
    parameter int IMG_W = 8,
    parameter int AW    = 8,
    parameter int RW    = 3,
    parameter int CW    = 3
) (
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic [AW-1:0] addr [TAPS],
    output logic          ok   [TAPS]
);
    localparam int PLANE = IMG_H * IMG_W;

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        localparam int IC = k / (KDIM * KDIM);
        localparam int DY = (k % (KDIM * KDIM)) / KDIM;
        localparam int DX = k % KDIM;
        int iy;
        int ix;
        always_comb begin
            iy = int'(row) + DY - 1;
            ix = int'(col) + DX - 1;
            ok[k] = (iy >= 0) && (iy < IMG_H) && (ix >= 0) && (ix < IMG_W);
            if (ok[k])
                addr[k] = AW'(IC * PLANE + iy * IMG_W + ix);
            else
                addr[k] = '0;
        end
    end
endmodule

// File: rtl/row_mac_cell.sv
module row_mac_cell
    import ws_row_pkg::*;
#(
    parameter int STAGES = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic signed [PIX_W-1:0] x_in,
    input  logic signed [PIX_W-1:0] w_in,
    input  logic signed [ACC_W-1:0] psum_in,
    output logic signed [ACC_W-1:0] psum_out
);
    logic signed [PIX_W-1:0]   x_al;
    logic signed [2*PIX_W-1:0] prod;

    if (STAGES == 0) begin : g_nodly
        assign x_al = x_in;
    end else begin : g_dly
        logic signed [PIX_W-1:0] chain [STAGES];
        always_ff @(posedge clk) begin
            chain[0] <= x_in;
            for (int i = 1; i < STAGES; i++)
                chain[i] <= chain[i-1];
        end
        assign x_al = chain[STAGES-1];
    end

    assign prod = x_al * w_in;

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            psum_out <= '0;
        else
            psum_out <= psum_in + {{(ACC_W-2*PIX_W){prod[2*PIX_W-1]}}, prod};
    end
endmodule

// File: rtl/row_ctrl.sv
module row_ctrl
    import ws_row_pkg::*;
#(
    parameter int IMG_H = 8,
    parameter int IMG_W = 8,
    parameter int N_OCH = 4,
    parameter int RW    = 3,
    parameter int CW    = 3,
    parameter int CHW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           pipe_busy,
    output logic           clr,
    output logic           issue,
    output logic           done,
    output logic [RW-1:0]  row,
    output logic [CW-1:0]  col,
    output logic [CHW-1:0] ch
);
    row_state_e st, nxt;
    logic last_pix, last_ch;

    assign last_pix = (row == RW'(IMG_H - 1)) && (col == CW'(IMG_W - 1));
    assign last_ch  = (ch == CHW'(N_OCH - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:  if (start) nxt = ST_CLEAR;
            ST_CLEAR: nxt = ST_ISSUE;
            ST_ISSUE: if (last_pix) nxt = ST_DRAIN;
            ST_DRAIN: if (!pipe_busy) nxt = last_ch ? ST_DONE : ST_CLEAR;
            ST_DONE:  if (start) nxt = ST_CLEAR;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        clr   = (st == ST_CLEAR);
        issue = (st == ST_ISSUE);
        done  = (st == ST_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
            ch  <= '0;
        end else begin
            if (st == ST_CLEAR) begin
                row <= '0;
                col <= '0;
            end else if (st == ST_ISSUE && !last_pix) begin
                if (col == CW'(IMG_W - 1)) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end
            if ((st == ST_IDLE || st == ST_DONE) && start)
                ch <= '0;
            else if (st == ST_DRAIN && !pipe_busy && !last_ch)
                ch <= ch + 1'b1;
        end
    end

    assert_clr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);
    assert_issue_follows_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> issue);
    assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

// File: rtl/ws_conv_row.sv
module ws_conv_row
    import ws_row_pkg::*;
#(
    parameter int IMG_H = 8,
    parameter int IMG_W = 8,
    parameter int N_OCH = 4,
    localparam int DEPTH = IN_CH * IMG_H * IMG_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CHW   = (N_OCH > 1) ? $clog2(N_OCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    pix_we,
    input  logic [AW-1:0]           pix_addr,
    input  logic signed [PIX_W-1:0] pix_data,
    input  logic                    wt_we,
    input  logic [TAP_IW-1:0]       wt_idx,
    input  logic signed [PIX_W-1:0] wt_data,
    output logic                    mem_valid,
    output logic signed [ACC_W-1:0] mem_value,
    output logic [CHW-1:0]          out_ch,
    output logic                    chan_clr,
    output logic                    layer_done
);
    localparam int RW  = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam int CW  = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int LIM = TAPS * (2 ** (2 * PIX_W - 2));

    logic                    issue;
    logic [RW-1:0]           row;
    logic [CW-1:0]           col;
    logic [TAPS-1:0]         vld_sr;
    logic [AW-1:0]           tap_addr [TAPS];
    logic                    tap_ok   [TAPS];
    logic signed [PIX_W-1:0] tap_pix  [TAPS];
    logic signed [PIX_W-1:0] wt_sh    [TAPS];
    logic signed [PIX_W-1:0] wt_act   [TAPS];
    logic signed [ACC_W-1:0] psum     [TAPS];
    logic [TAPS*PIX_W-1:0]   wt_act_flat;

    row_ctrl #(.IMG_H(IMG_H), .IMG_W(IMG_W), .N_OCH(N_OCH),
               .RW(RW), .CW(CW), .CHW(CHW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .pipe_busy(|vld_sr),
        .clr(chan_clr), .issue(issue), .done(layer_done),
        .row(row), .col(col), .ch(out_ch)
    );

    row_addr_gen #(.IMG_H(IMG_H), .IMG_W(IMG_W), .AW(AW),
                   .RW(RW), .CW(CW)) u_agen (
        .row(row), .col(col), .addr(tap_addr), .ok(tap_ok)
    );

    row_img_store #(.DEPTH(DEPTH), .AW(AW)) u_img (
        .clk(clk), .we(pix_we), .waddr(pix_addr), .wdata(pix_data),
        .raddr(tap_addr), .rok(tap_ok), .rdata(tap_pix)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) begin
                wt_sh[k]  <= '0;
                wt_act[k] <= '0;
            end
        end else begin
            if (wt_we && (int'(wt_idx) < TAPS))
                wt_sh[wt_idx] <= wt_data;
            if (chan_clr)
                for (int k = 0; k < TAPS; k++)
                    wt_act[k] <= wt_sh[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_sr <= '0;
        else        vld_sr <= {vld_sr[TAPS-2:0], issue};
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_pe
        logic signed [ACC_W-1:0] pin;
        if (k == 0) begin : g_first
            assign pin = '0;
        end else begin : g_next
            assign pin = psum[k-1];
        end
        row_mac_cell #(.STAGES(k)) u_cell (
            .clk(clk), .rst_n(rst_n), .clr(chan_clr),
            .x_in(tap_pix[k]), .w_in(wt_act[k]),
            .psum_in(pin), .psum_out(psum[k])
        );
        assign wt_act_flat[k*PIX_W +: PIX_W] = wt_act[k];
    end

    assign mem_valid = vld_sr[TAPS-1];
    assign mem_value = psum[TAPS-1];

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (int'(mem_value) <= LIM && int'(mem_value) >= -LIM));
    assert_enable_quiet_in_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chan_clr |-> !mem_valid);
    assert_weights_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_clr |=> $stable(wt_act_flat));
endmodule

// File: tb/ws_conv_row_tb_top.sv
module ws_conv_row_tb_top;
    localparam int H = 8;
    localparam int W = 8;
    localparam int NO = 4;
    localparam int NT = 27;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0;
    logic pix_we = 0;
    logic [7:0] pix_addr = '0;
    logic signed [7:0] pix_data = '0;
    logic wt_we = 0;
    logic [4:0] wt_idx = '0;
    logic signed [7:0] wt_data = '0;
    logic mem_valid;
    logic signed [23:0] mem_value;
    logic [1:0] out_ch;
    logic chan_clr;
    logic layer_done;

    always #10 clk = ~clk;

    ws_conv_row #(.IMG_H(H), .IMG_W(W), .N_OCH(NO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pix_we(pix_we), .pix_addr(pix_addr), .pix_data(pix_data),
        .wt_we(wt_we), .wt_idx(wt_idx), .wt_data(wt_data),
        .mem_valid(mem_valid), .mem_value(mem_value), .out_ch(out_ch),
        .chan_clr(chan_clr), .layer_done(layer_done)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int img_m [3][H][W];
    int sh_m [NT];
    int act_m [NT];
    int wset [NO][NT];
    int exp_q [$];
    int bord_q [$];
    int cyc = 0;
    int clr_cyc = 0;
    int nout = 0;
    int nclr = 0;
    int cur_ch = 0;
    bit prev_clr = 0;
    bit extreme = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int y, input int x);
        int s = 0;
        for (int i = 0; i < 3; i++)
            for (int dy = 0; dy < 3; dy++)
                for (int dx = 0; dx < 3; dx++) begin
                    int r = y + dy - 1;
                    int q = x + dx - 1;
                    if (r >= 0 && r < H && q >= 0 && q < W)
                        s += act_m[i*9 + dy*3 + dx] * img_m[i][r][q];
                end
        return s;
    endfunction

    // cycle-by-cycle reference: clear pulses, enable timing, values, channel
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (chan_clr) begin
                check(!prev_clr, "R5 single-cycle clear", 1, 0);
                check(!mem_valid, "R4 enable low during clear", mem_valid, 0);
                act_m = sh_m;
                cur_ch = nclr;
                nclr++;
                clr_cyc = cyc;
                nout = 0;
                for (int y = 0; y < H; y++)
                    for (int x = 0; x < W; x++) begin
                        exp_q.push_back(model(y, x));
                        bord_q.push_back((y == 0 || y == H-1 || x == 0 || x == W-1) ? 1 : 0);
                    end
            end
            if (mem_valid) begin
                int e;
                int b;
                check(cyc == clr_cyc + 28 + nout, "R4 result cycle", cyc - clr_cyc, 28 + nout);
                check(int'(out_ch) == cur_ch, "R9 channel index", int'(out_ch), cur_ch);
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected result", int'(mem_value), 0);
                end else begin
                    e = exp_q.pop_front();
                    b = bord_q.pop_front();
                    if (extreme)
                        check(int'(mem_value) == e, "R8 wide accumulation", int'(mem_value), e);
                    else if (b != 0)
                        check(int'(mem_value) == e, "R3 border padding", int'(mem_value), e);
                    else
                        check(int'(mem_value) == e, "R2 interior value", int'(mem_value), e);
                end
                nout++;
            end
            prev_clr = chan_clr;
        end
    end

    task automatic wr_pix(input int a, input int v);
        pix_we = 1; pix_addr = 8'(a); pix_data = 8'(v);
        @(posedge clk);
        img_m[a / (H*W)][(a % (H*W)) / W][a % W] = v;
        @(negedge clk);
        pix_we = 0;
    endtask

    task automatic wr_wt(input int i, input int v);
        wt_we = 1; wt_idx = 5'(i); wt_data = 8'(v);
        @(posedge clk);
        if (i < NT) sh_m[i] = v;
        @(negedge clk);
        wt_we = 0;
    endtask

    task automatic wait_clr();
        @(negedge clk);
        while (!chan_clr) @(negedge clk);
    endtask

    task automatic run_layer();
        nclr = 0;
        for (int k = 0; k < NT; k++) wr_wt(k, wset[0][k]);
        start = 1;
        @(negedge clk);
        start = 0;
        check(chan_clr == 1'b1, "R5 clear after start", chan_clr, 1);
        for (int c = 0; c < NO; c++) begin
            if (c > 0) wait_clr();
            // R6: shadow writes while the current channel runs
            for (int k = 0; k < NT; k++)
                wr_wt(k, (c == NO-1) ? ((k * 37 + 5) % 256 - 128) : wset[c+1][k]);
            if (c == 1) begin
                // R7: start during a running layer must be ignored
                start = 1;
                @(negedge clk);
                start = 0;
            end
        end
        while (!layer_done) @(negedge clk);
        check(exp_q.size() == 0, "R7 done after last result", exp_q.size(), 0);
        check(nclr == NO, "R5 clear count", nclr, NO);
        repeat (3) @(negedge clk);
        check(layer_done == 1'b1, "R7 done held", layer_done, 1);
    endtask

    task automatic finish_all();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(mem_valid == 0, "R1 reset valid", mem_valid, 0);
        check(chan_clr == 0, "R1 reset clear", chan_clr, 0);
        check(layer_done == 0, "R1 reset done", layer_done, 0);
        rst_n = 1;
        @(negedge clk);

        // pass A: random image, corners at extremes, random weights per channel
        for (int a = 0; a < 3*H*W; a++) begin
            int x = a % W;
            int y = (a % (H*W)) / W;
            int v = int'($urandom_range(255)) - 128;
            if ((x == 0 || x == W-1) && (y == 0 || y == H-1))
                v = (x == 0) ? 127 : -128;
            wr_pix(a, v);
        end
        for (int c = 0; c < NO; c++)
            for (int k = 0; k < NT; k++)
                wset[c][k] = int'($urandom_range(255)) - 128;
        run_layer();

        // pass B: every pixel and weight at -128 (R8)
        for (int a = 0; a < 3*H*W; a++) wr_pix(a, -128);
        for (int c = 0; c < NO; c++)
            for (int k = 0; k < NT; k++)
                wset[c][k] = -128;
        extreme = 1;
        run_layer();
        check(model(3, 3) == 442368, "R8 reference interior", model(3, 3), 442368);
        finish_all();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(0, "watchdog", 0, 1);
            finish_all();
        end
    end
endmodule